// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from the processor core and decides, once per instruction boundary, which request the core should service next. Every peripheral request is a status flag paired with an enable. Several pairs may feed one source index, as the serial port does with its four conditions. The core contributes three requests of its own: a software trap, an illegal-opcode trap and a non-maskable-style line that is gated by the X bit of the condition code register. A 32-bit pending mask holds the state of every source index.

Selection uses a fixed front end and a programmable back end. The two traps come first and ignore both mask bits. The X-gated line comes next, and while it is pending with X set it blocks all service. With I set, only those three can win. Otherwise the first pending index met while walking a writable order table is chosen. The block presents the chosen index and the address of its 16-bit vector, which is the table base plus twice the index. When the core strobes a take, the block commands it to set X (for the X-gated line) or I (for everything else). It then holds off further takes for the fixed 14-cycle service overhead. Peripheral pending bits follow their flags and are not cleared by a take, so a handler that leaves its flag set is entered again after return.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the pending mask is all zero, `irq_valid`, `set_x`, `set_i` and `svc_busy` are 0, and the order table holds the identity order (slot k names index k, so a lower index wins).
- R2: A peripheral pair p is active when `periph_flag[p]` and `periph_en[p]` are both 1. Its source index becomes pending one clock edge after the pair turns active and stops being pending one edge after it turns inactive. `vector_addr` equals the base plus 2 × `irq_id`. With the default mapping, pairs 0–3 feed index 11, pair 4 feeds 12, pair 5 feeds 15, pair 6 feeds 24 and pair 7 feeds 20.
- R3: An index fed by several pairs (index 11 from pairs 0–3) is pending whenever at least one of those pairs is active, regardless of the others.
- R4: A pending software trap (index 27) is selected first, and a pending illegal-opcode trap (index 28) second. Both ignore `x_mask` and `i_mask`. A trap's pending bit is cleared when it is taken.
- R5: Below the traps, a pending X-gated line (index 26) is selected when `x_mask` is 0 and is cleared when taken. When `x_mask` is 1, nothing at all is selected while it is pending, even if other sources are pending.
- R6: With `i_mask` = 1, no source other than indices 27, 28 and 26 is selected.
- R7: Otherwise the selected index is the pending one held in the lowest-numbered slot of the order table. A write with `ord_we` = 1 stores `ord_src` into slot `ord_slot` at the clock edge and affects selection from then on.
- R8: While `take_strobe` is 1, a selection is present and the block is not busy, `set_x` is 1 if the selection is index 26, and `set_i` is 1 for any other index. Both are 0 otherwise.
- R9: Taking a peripheral index leaves its pending bit set for as long as its pair stays active.
- R10: After an accepted take, `svc_busy` is 1 for exactly 14 clock cycles. During those cycles a strobe is ignored: no set command is issued and no pending bit is cleared.
- R11: The vector base is captured from `boot_mode` while reset is asserted: 0xFFC0 when it is 0 and 0xBFC0 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset: asynchronous for state, and also the capture window for `boot_mode` |
| boot_mode | input | 1 | Selects the bootstrap vector base when sampled during reset |
| periph_flag | input | 8 | Peripheral status flags, one per pair |
| periph_en | input | 8 | Peripheral enables, one per pair |
| swi_req | input | 1 | Software trap request pulse |
| ill_req | input | 1 | Illegal-opcode trap request pulse |
| xirq_req | input | 1 | X-gated line request pulse |
| x_mask | input | 1 | X bit of the condition code register |
| i_mask | input | 1 | I bit of the condition code register |
| take_strobe | input | 1 | Core is at an instruction boundary and takes the selection |
| ord_we | input | 1 | Order table write enable |
| ord_slot | input | 5 | Order table slot to write |
| ord_src | input | 5 | Source index stored into the slot |
| irq_valid | output | 1 | A source is selected |
| irq_id | output | 5 | Selected source index |
| vector_addr | output | 16 | Address of the selected vector |
| set_x | output | 1 | Command the core to set X |
| set_i | output | 1 | Command the core to set I |
| svc_busy | output | 1 | Service overhead window in progress |

## Verification
Request inputs and flag changes reach the pending mask at the next rising edge, and selection and vector are combinational from it. The bench therefore changes inputs just after a falling edge and compares `irq_valid`, `irq_id` and `vector_addr` at the following falling edge. `set_x` and `set_i` follow `take_strobe` without a register, so they are sampled one time unit after the strobe is raised and before the edge that accepts it. Pending clears from a take appear at the next falling edge. `svc_busy` is sampled at the 1st and 14th falling edges after the accepting edge, where it must be high, and at the 15th, where it must be low.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   localparam int DEF_SRC_CNT   = 32;
   localparam int DEF_SWI_IDX   = 27;
   localparam int DEF_ILL_IDX   = 28;
   localparam int DEF_XL_IDX    = 26;
   localparam int DEF_OVERHEAD  = 14;
   localparam logic [15:0] DEF_BASE_NORM = 16'hFFC0;
   localparam logic [15:0] DEF_BASE_BOOT = 16'hBFC0;

   // Class of the current winner, used to route the mask-set command.
   typedef enum logic [1:0] {
      PICK_NONE  = 2'd0,
      PICK_TRAP  = 2'd1,
      PICK_XLINE = 2'd2,
      PICK_TABLE = 2'd3
   } pick_e;

endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
   parameter int SRC_CNT = 32,
   parameter int ID_W    = 5,
   parameter int PAIRS   = 8,
   parameter int PAIR_MAP [PAIRS] = '{default: 0},
   parameter int SWI_IDX = 27,
   parameter int ILL_IDX = 28,
   parameter int XL_IDX  = 26
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PAIRS-1:0]   flag,
   input  logic [PAIRS-1:0]   en,
   input  logic               swi_req,
   input  logic               ill_req,
   input  logic               xl_req,
   input  logic               take_ok,
   input  logic [ID_W-1:0]    take_id,
   output logic [SRC_CNT-1:0] pend_q
);

   function automatic logic [SRC_CNT-1:0] mapped_set();
      logic [SRC_CNT-1:0] m;
      m = '0;
      for (int p = 0; p < PAIRS; p++) m[PAIR_MAP[p]] = 1'b1;
      return m;
   endfunction

   localparam logic [SRC_CNT-1:0] MAPPED = mapped_set();

   logic [SRC_CNT-1:0] level;
   logic [SRC_CNT-1:0] pend_d;

   // Only sets are written; an index with no active pair stays 0, which
   // is the clear-before-set rule for shared indices.
   always_comb begin
      level = '0;
      for (int p = 0; p < PAIRS; p++) begin
         if (flag[p] && en[p]) level[ID_W'(PAIR_MAP[p])] = 1'b1;
      end
   end

   for (genvar s = 0; s < SRC_CNT; s++) begin : g_src
      if (s == SWI_IDX) begin : g_swi
         assign pend_d[s] = (pend_q[s] & ~(take_ok && take_id == ID_W'(s))) | swi_req;
      end else if (s == ILL_IDX) begin : g_ill
         assign pend_d[s] = (pend_q[s] & ~(take_ok && take_id == ID_W'(s))) | ill_req;
      end else if (s == XL_IDX) begin : g_xl
         assign pend_d[s] = (pend_q[s] & ~(take_ok && take_id == ID_W'(s))) | xl_req;
      end else if (MAPPED[s]) begin : g_per
         assign pend_d[s] = level[s];
      end else begin : g_idle
         assign pend_d[s] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

endmodule

// File: rtl/ivc_order_tbl.sv
module ivc_order_tbl #(
   parameter int SRC_CNT = 32,
   parameter int ID_W    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ID_W-1:0]    wr_slot,
   input  logic [ID_W-1:0]    wr_src,
   input  logic [SRC_CNT-1:0] pend,
   output logic               hit,
   output logic [ID_W-1:0]    hit_id
);

   logic [ID_W-1:0] tbl [SRC_CNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SRC_CNT; k++) tbl[k] <= ID_W'(k);
      end else if (wr_en) begin
         tbl[wr_slot] <= wr_src;
      end
   end

   // Walk from the last slot down so the lowest matching slot is left.
   always_comb begin
      hit    = 1'b0;
      hit_id = '0;
      for (int k = SRC_CNT - 1; k >= 0; k--) begin
         if (pend[tbl[k]]) begin
            hit    = 1'b1;
            hit_id = tbl[k];
         end
      end
   end

endmodule

// File: rtl/ivc_select.sv
module ivc_select
   import ivc_pkg::*;
#(
   parameter int SRC_CNT = 32,
   parameter int ID_W    = 5,
   parameter int SWI_IDX = 27,
   parameter int ILL_IDX = 28,
   parameter int XL_IDX  = 26
) (
   input  logic [SRC_CNT-1:0] pend,
   input  logic               x_mask,
   input  logic               i_mask,
   input  logic               tbl_hit,
   input  logic [ID_W-1:0]    tbl_id,
   output logic               valid,
   output logic [ID_W-1:0]    id,
   output pick_e              kind
);

   always_comb begin
      valid = 1'b0;
      id    = '0;
      kind  = PICK_NONE;
      if (pend[SWI_IDX]) begin
         valid = 1'b1;
         id    = ID_W'(SWI_IDX);
         kind  = PICK_TRAP;
      end else if (pend[ILL_IDX]) begin
         valid = 1'b1;
         id    = ID_W'(ILL_IDX);
         kind  = PICK_TRAP;
      end else if (pend[XL_IDX]) begin
         // A masked line holds everything below it.
         if (!x_mask) begin
            valid = 1'b1;
            id    = ID_W'(XL_IDX);
            kind  = PICK_XLINE;
         end
      end else if (!i_mask && tbl_hit) begin
         valid = 1'b1;
         id    = tbl_id;
         kind  = PICK_TABLE;
      end
   end

endmodule

// File: rtl/ivc_overhead.sv
module ivc_overhead #(
   parameter int CYCLES = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);

   if (CYCLES == 0) begin : g_none
      assign busy = 1'b0;
   end else begin : g_cnt
      localparam int CNT_W = $clog2(CYCLES + 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (load)       cnt <= CNT_W'(CYCLES);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end

      assign busy = (cnt != '0);
   end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int SRC_CNT  = DEF_SRC_CNT,
   parameter int PAIRS    = 8,
   parameter int PAIR_MAP [PAIRS] = '{11, 11, 11, 11, 12, 15, 24, 20},
   parameter int SWI_IDX  = DEF_SWI_IDX,
   parameter int ILL_IDX  = DEF_ILL_IDX,
   parameter int XL_IDX   = DEF_XL_IDX,
   parameter logic [15:0] BASE_NORM = DEF_BASE_NORM,
   parameter logic [15:0] BASE_BOOT = DEF_BASE_BOOT,
   parameter bit HAS_BOOT = 1'b1,
   parameter int OVERHEAD = DEF_OVERHEAD,
   localparam int ID_W    = $clog2(SRC_CNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_mode,
   input  logic [PAIRS-1:0] periph_flag,
   input  logic [PAIRS-1:0] periph_en,
   input  logic             swi_req,
   input  logic             ill_req,
   input  logic             xirq_req,
   input  logic             x_mask,
   input  logic             i_mask,
   input  logic             take_strobe,
   input  logic             ord_we,
   input  logic [ID_W-1:0]  ord_slot,
   input  logic [ID_W-1:0]  ord_src,
   output logic             irq_valid,
   output logic [ID_W-1:0]  irq_id,
   output logic [15:0]      vector_addr,
   output logic             set_x,
   output logic             set_i,
   output logic             svc_busy
);

   // ---------------- elaboration checks ----------------
   if (SRC_CNT < 4 || SRC_CNT > 32 || (1 << ID_W) != SRC_CNT) begin : g_bad_cnt
      $error("SRC_CNT must be a power of two between 4 and 32");
   end
   if (SWI_IDX >= SRC_CNT || ILL_IDX >= SRC_CNT || XL_IDX >= SRC_CNT) begin : g_bad_core
      $error("core source index out of range");
   end
   if (SWI_IDX == ILL_IDX || SWI_IDX == XL_IDX || ILL_IDX == XL_IDX) begin : g_dup_core
      $error("core source indices must differ");
   end
   if (32'(BASE_NORM) + 2 * (SRC_CNT - 1) > 32'hFFFF ||
       32'(BASE_BOOT) + 2 * (SRC_CNT - 1) > 32'hFFFF) begin : g_bad_base
      $error("vector table does not fit below 0x10000");
   end
   for (genvar p = 0; p < PAIRS; p++) begin : g_chk_map
      if (PAIR_MAP[p] < 0 || PAIR_MAP[p] >= SRC_CNT ||
          PAIR_MAP[p] == SWI_IDX || PAIR_MAP[p] == ILL_IDX ||
          PAIR_MAP[p] == XL_IDX) begin : g_bad_map
         $error("peripheral pair maps to an invalid or core index");
      end
   end

   // ---------------- vector base ----------------
   logic [15:0] base;

   if (HAS_BOOT) begin : g_boot
      logic boot_q;
      always_ff @(posedge clk) begin
         if (!rst_n) boot_q <= boot_mode;
      end
      assign base = boot_q ? BASE_BOOT : BASE_NORM;
   end else begin : g_fixed
      logic unused_boot;
      assign unused_boot = boot_mode;
      assign base = BASE_NORM;
   end

   // ---------------- datapath ----------------
   logic [SRC_CNT-1:0] pend_q;
   logic               tbl_hit;
   logic [ID_W-1:0]    tbl_id;
   pick_e              kind;
   logic               take_ok;

   assign take_ok = take_strobe && irq_valid && !svc_busy;

   ivc_pending #(
      .SRC_CNT (SRC_CNT),
      .ID_W    (ID_W),
      .PAIRS   (PAIRS),
      .PAIR_MAP(PAIR_MAP),
      .SWI_IDX (SWI_IDX),
      .ILL_IDX (ILL_IDX),
      .XL_IDX  (XL_IDX)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag   (periph_flag),
      .en     (periph_en),
      .swi_req(swi_req),
      .ill_req(ill_req),
      .xl_req (xirq_req),
      .take_ok(take_ok),
      .take_id(irq_id),
      .pend_q (pend_q)
   );

   ivc_order_tbl #(
      .SRC_CNT(SRC_CNT),
      .ID_W   (ID_W)
   ) u_order (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ord_we),
      .wr_slot(ord_slot),
      .wr_src (ord_src),
      .pend   (pend_q),
      .hit    (tbl_hit),
      .hit_id (tbl_id)
   );

   ivc_select #(
      .SRC_CNT(SRC_CNT),
      .ID_W   (ID_W),
      .SWI_IDX(SWI_IDX),
      .ILL_IDX(ILL_IDX),
      .XL_IDX (XL_IDX)
   ) u_sel (
      .pend   (pend_q),
      .x_mask (x_mask),
      .i_mask (i_mask),
      .tbl_hit(tbl_hit),
      .tbl_id (tbl_id),
      .valid  (irq_valid),
      .id     (irq_id),
      .kind   (kind)
   );

   ivc_overhead #(
      .CYCLES(OVERHEAD)
   ) u_ovh (
      .clk  (clk),
      .rst_n(rst_n),
      .load (take_ok),
      .busy (svc_busy)
   );

   assign vector_addr = base + 16'({irq_id, 1'b0});
   assign set_x       = take_ok && (kind == PICK_XLINE);
   assign set_i       = take_ok && (kind != PICK_XLINE);

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
   parameter int SRC_CNT = 32,
   parameter int ID_W    = 5,
   parameter int SWI_IDX = 27,
   parameter int ILL_IDX = 28,
   parameter int XL_IDX  = 26
) (
   input logic               clk,
   input logic               rst_n,
   input logic               take_strobe,
   input logic               x_mask,
   input logic               i_mask,
   input logic               swi_req,
   input logic [SRC_CNT-1:0] pend,
   input logic               irq_valid,
   input logic [ID_W-1:0]    irq_id,
   input logic [15:0]        vector_addr,
   input logic               set_x,
   input logic               set_i,
   input logic               svc_busy
);

   // R4: a pending software trap always wins.
   p_swi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend[SWI_IDX] |-> (irq_valid && irq_id == ID_W'(SWI_IDX)));

   // R4: taking the software trap clears it unless a new request arrives.
   p_swi_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && irq_id == ID_W'(SWI_IDX) && !swi_req) |=> !pend[SWI_IDX]);

   // R5: masked X-gated line blocks all service below the traps.
   p_xline_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[XL_IDX] && x_mask && !pend[SWI_IDX] && !pend[ILL_IDX]) |-> !irq_valid);

   // R6: I set leaves only the traps and the X-gated line.
   p_imask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (i_mask && irq_valid) |-> (irq_id == ID_W'(SWI_IDX) ||
                                 irq_id == ID_W'(ILL_IDX) ||
                                 irq_id == ID_W'(XL_IDX)));

   // R8: X set command only for the X-gated line, on a strobe, never with I.
   p_setx_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_x |-> (take_strobe && irq_id == ID_W'(XL_IDX) && !set_i));

   // R8: I set command only on a strobe with a selection.
   p_seti_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |-> (take_strobe && irq_valid));

   // R10: an accepted take opens the overhead window.
   p_busy_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (set_x || set_i) |=> svc_busy);

   // R10: no command during the overhead window.
   p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      svc_busy |-> (!set_x && !set_i));

   // R2: vectors are 16-bit aligned.
   p_vec_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (vector_addr[0] == 1'b0));

endmodule

bind irq_vector_ctrl ivc_checker #(
   .SRC_CNT(SRC_CNT),
   .ID_W   (ID_W),
   .SWI_IDX(SWI_IDX),
   .ILL_IDX(ILL_IDX),
   .XL_IDX (XL_IDX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .take_strobe(take_strobe),
   .x_mask     (x_mask),
   .i_mask     (i_mask),
   .swi_req    (swi_req),
   .pend       (pend_q),
   .irq_valid  (irq_valid),
   .irq_id     (irq_id),
   .vector_addr(vector_addr),
   .set_x      (set_x),
   .set_i      (set_i),
   .svc_busy   (svc_busy)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int IDX_SWI = 27;
   localparam int IDX_ILL = 28;
   localparam int IDX_XL  = 26;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boot_mode = 1'b0;
   logic [7:0] periph_flag = '0;
   logic [7:0] periph_en = '0;
   logic       swi_req = 1'b0, ill_req = 1'b0, xirq_req = 1'b0;
   logic       x_mask = 1'b0, i_mask = 1'b0;
   logic       take_strobe = 1'b0;
   logic       ord_we = 1'b0;
   logic [4:0] ord_slot = '0, ord_src = '0;
   logic       irq_valid;
   logic [4:0] irq_id;
   logic [15:0] vector_addr;
   logic       set_x, set_i, svc_busy;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // Bench-side configuration and model state
   int  map_m [8] = '{11, 11, 11, 11, 12, 15, 24, 20};
   int  ord_m [32];
   bit  m_swi, m_ill, m_xl;
   int  base_m;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
      .periph_flag(periph_flag), .periph_en(periph_en),
      .swi_req(swi_req), .ill_req(ill_req), .xirq_req(xirq_req),
      .x_mask(x_mask), .i_mask(i_mask), .take_strobe(take_strobe),
      .ord_we(ord_we), .ord_slot(ord_slot), .ord_src(ord_src),
      .irq_valid(irq_valid), .irq_id(irq_id), .vector_addr(vector_addr),
      .set_x(set_x), .set_i(set_i), .svc_busy(svc_busy)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic void model(output bit v, output int id);
      bit [31:0] p;
      p = '0;
      for (int k = 0; k < 8; k++)
         if (periph_flag[k] && periph_en[k]) p[map_m[k]] = 1'b1;
      p[IDX_SWI] = m_swi;
      p[IDX_ILL] = m_ill;
      p[IDX_XL]  = m_xl;
      v = 1'b0; id = 0;
      if (p[IDX_SWI]) begin v = 1; id = IDX_SWI; end
      else if (p[IDX_ILL]) begin v = 1; id = IDX_ILL; end
      else if (p[IDX_XL]) begin
         if (!x_mask) begin v = 1; id = IDX_XL; end
      end else if (!i_mask) begin
         for (int k = 31; k >= 0; k--)
            if (p[ord_m[k]]) begin v = 1; id = ord_m[k]; end
      end
   endfunction

   task automatic check_sel(input string rq);
      bit v; int id;
      model(v, id);
      if (v)
         chk(irq_valid && int'(irq_id) == id &&
             int'(vector_addr) == base_m + 2 * id, rq, "id/vector",
             irq_valid ? int'(vector_addr) : -1, base_m + 2 * id);
      else
         chk(!irq_valid, rq, "valid", int'(irq_valid), 0);
   endtask

   task automatic do_reset(input bit boot);
      rst_n = 1'b0;
      boot_mode = boot;
      periph_flag = '0; periph_en = '0;
      swi_req = 0; ill_req = 0; xirq_req = 0;
      x_mask = 0; i_mask = 0; take_strobe = 0; ord_we = 0;
      m_swi = 0; m_ill = 0; m_xl = 0;
      for (int k = 0; k < 32; k++) ord_m[k] = k;
      base_m = boot ? 32'hBFC0 : 32'hFFC0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Strobe a take; checks commands before the edge, returns one falling
   // edge after the accepting edge.
   task automatic take_now(input string rq, input bit exp_x, input bit exp_i);
      take_strobe = 1'b1;
      #1;
      chk(set_x == exp_x, rq, "set_x", int'(set_x), int'(exp_x));
      chk(set_i == exp_i, rq, "set_i", int'(set_i), int'(exp_i));
      @(negedge clk);
      take_strobe = 1'b0;
   endtask

   task automatic wait_window(input string rq);
      chk(svc_busy == 1'b1, rq, "busy first", int'(svc_busy), 1);
      repeat (13) @(negedge clk);
      chk(svc_busy == 1'b1, rq, "busy last", int'(svc_busy), 1);
      @(negedge clk);
      chk(svc_busy == 1'b0, rq, "busy end", int'(svc_busy), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      // ---- R1 reset state ----
      @(negedge clk);
      chk(!irq_valid && !set_x && !set_i && !svc_busy, "R1", "outputs in reset",
          int'({irq_valid, set_x, set_i, svc_busy}), 0);
      do_reset(1'b0);
      chk(!irq_valid && !svc_busy, "R1", "outputs after reset",
          int'({irq_valid, svc_busy}), 0);
      // identity order: 20 wins over 24
      periph_en = 8'hFF; periph_flag = 8'hC0;
      @(negedge clk);
      chk(irq_valid && irq_id == 5'd20, "R1", "identity order", int'(irq_id), 20);

      // ---- R2/R3 sweeps ----
      periph_en = 8'hFF;
      for (int f = 0; f < 256; f++) begin
         periph_flag = 8'(f);
         @(negedge clk);
         check_sel("R2 flag sweep");
      end
      periph_flag = 8'hFF;
      for (int e = 0; e < 256; e++) begin
         periph_en = 8'(e);
         @(negedge clk);
         check_sel("R2 enable sweep");
      end
      // R3: each serial pair alone keeps index 11 pending
      periph_en = 8'hFF;
      for (int q = 0; q < 4; q++) begin
         periph_flag = 8'(1 << q);
         @(negedge clk);
         chk(irq_valid && irq_id == 5'd11, "R3", "shared index", int'(irq_id), 11);
      end
      periph_flag = '0;
      @(negedge clk);
      chk(!irq_valid, "R2", "flag cleared", int'(irq_valid), 0);

      // ---- R4/R5/R6 core request and mask combinations ----
      for (int c = 0; c < 32; c++) begin
         do_reset(1'b0);
         periph_en = 8'hFF; periph_flag = 8'h20;
         swi_req = c[0]; ill_req = c[1]; xirq_req = c[2];
         x_mask = c[3]; i_mask = c[4];
         m_swi = c[0]; m_ill = c[1]; m_xl = c[2];
         @(negedge clk);
         swi_req = 0; ill_req = 0; xirq_req = 0;
         check_sel("R4 R5 R6 priority");
      end

      // ---- R8/R10/R4/R5/R9 take sequence ----
      do_reset(1'b0);
      periph_en = 8'hFF; periph_flag = 8'h20;
      swi_req = 1; ill_req = 1; xirq_req = 1;
      m_swi = 1; m_ill = 1; m_xl = 1;
      @(negedge clk);
      swi_req = 0; ill_req = 0; xirq_req = 0;
      check_sel("R4 all pending");
      take_now("R8 trap take", 1'b0, 1'b1);
      m_swi = 0;
      check_sel("R4 trap cleared");
      // strobe while busy is ignored
      take_now("R10 ignored take", 1'b0, 1'b0);
      chk(irq_valid && irq_id == 5'd28, "R10", "pending kept", int'(irq_id), 28);
      repeat (12) @(negedge clk);
      chk(svc_busy == 1'b1, "R10", "busy 14th", int'(svc_busy), 1);
      @(negedge clk);
      chk(svc_busy == 1'b0, "R10", "busy over", int'(svc_busy), 0);
      take_now("R8 ill take", 1'b0, 1'b1);
      m_ill = 0;
      wait_window("R10");
      check_sel("R5 xline next");
      take_now("R8 xline take", 1'b1, 1'b0);
      m_xl = 0;
      wait_window("R10");
      check_sel("R5 xline cleared");
      chk(irq_valid && irq_id == 5'd15, "R9", "peripheral before take", int'(irq_id), 15);
      take_now("R8 peripheral take", 1'b0, 1'b1);
      chk(irq_valid && irq_id == 5'd15, "R9", "peripheral kept", int'(irq_id), 15);
      wait_window("R10");
      chk(irq_valid && irq_id == 5'd15, "R9", "peripheral re-raised", int'(irq_id), 15);
      periph_flag = '0;
      @(negedge clk);
      chk(!irq_valid, "R9", "cleared by flag", int'(irq_valid), 0);

      // ---- R7 order table ----
      periph_flag = 8'hC0;
      ord_we = 1; ord_slot = 5'd0; ord_src = 5'd24;
      ord_m[0] = 24;
      @(negedge clk);
      ord_we = 0;
      chk(irq_valid && irq_id == 5'd24, "R7", "reordered winner", int'(irq_id), 24);
      check_sel("R7 model");
      ord_we = 1; ord_slot = 5'd0; ord_src = 5'd31;
      ord_m[0] = 31;
      @(negedge clk);
      ord_we = 0;
      chk(irq_valid && irq_id == 5'd20, "R7", "unpended slot skipped", int'(irq_id), 20);
      i_mask = 1;
      #1;
      chk(!irq_valid, "R6", "I blocks table", int'(irq_valid), 0);
      take_now("R8 no selection", 1'b0, 1'b0);
      i_mask = 0;

      // ---- R11 bootstrap base ----
      do_reset(1'b1);
      periph_en = 8'hFF; periph_flag = 8'h10;
      @(negedge clk);
      chk(irq_valid && vector_addr == 16'hBFD8, "R11", "boot vector",
          int'(vector_addr), 32'hBFD8);
      do_reset(1'b0);
      periph_en = 8'hFF; periph_flag = 8'h10;
      @(negedge clk);
      chk(irq_valid && vector_addr == 16'hFFD8, "R11", "normal vector",
          int'(vector_addr), 32'hFFD8);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule